// File: doc/BRIEF.md
# Change-of-state interrupt aggregator

This block collects a set of level-type status conditions coming from buffer controllers and signal detectors and reduces them to one active-low interrupt line. Every change of any condition, whether it asserts or clears, starts a low pulse of fixed length on the interrupt output. A host that sees the pulse reads two status words to find out which conditions are now active.

Each input is sampled once into a capture register and compared with the value it held one cycle before. A difference in any single-bit cause counts as an event. A difference in the 4-bit tone-pair code counts only while the tone-pair presence flag was high in both samples. A new event that arrives while a pulse is running reloads the pulse timer, so the line stays low until the full pulse length has passed after the last event.

Reset is synchronous. During reset, both the capture stage and the previous-value stage load the live inputs. As a result, conditions that are already active when reset is released do not raise an interrupt.

Top module: `irq_change_agg`

## Requirements
- R1: While reset is held, and after release for as long as no input changes, `irq_n` stays high.
- R2: A rising edge on any of `rx_underflow`, `tx_overrun`, `tone0_det`, `tone1_det`, `fsk_req` or `dsp_err` produces a low pulse on `irq_n`.
- R3: A falling edge on any of those six inputs also produces a low pulse on `irq_n`.
- R4: `dtmf_valid` produces a low pulse both when it rises and when it falls.
- R5: A change of `dtmf_code` while `dtmf_valid` was high in the previous and the current sample produces a pulse. A change of `dtmf_code` while `dtmf_valid` is low produces no pulse.
- R6: `dial_pulse` produces a low pulse both when it rises and when it falls.
- R7: An input applied before clock edge k drives `irq_n` low from edge k+1 through edge k+PULSE_CYCLES. `irq_n` is high again after edge k+PULSE_CYCLES+1.
- R8: An event during a running pulse restarts the timer, so `irq_n` stays low for PULSE_CYCLES cycles counted from the last event.
- R9: `stat_a` shows the inputs sampled at the previous edge: bit 0 underflow, bit 1 overrun, bit 3 tone0, bit 4 tone1, bit 6 FSK request, bit 7 DSP error. Bits 2 and 5 read 0.
- R10: `stat_b` shows the inputs sampled at the previous edge: bits 3:0 tone-pair code, bit 4 tone-pair presence, bit 6 dial pulse. Bits 5 and 7 read 0.
- R11: Several causes that change in the same cycle produce exactly one pulse of PULSE_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_underflow | input | 1 | Receive buffer underflow level |
| tx_overrun | input | 1 | Transmit buffer overrun level |
| tone0_det | input | 1 | Tone detector 0 level |
| tone1_det | input | 1 | Tone detector 1 level |
| fsk_req | input | 1 | FSK data request level |
| dsp_err | input | 1 | DSP error level |
| dtmf_valid | input | 1 | Tone-pair presence level |
| dtmf_code | input | 4 | Tone-pair code |
| dial_pulse | input | 1 | Dial-pulse detect level |
| irq_n | output | 1 | Interrupt pulse, active low |
| stat_a | output | 8 | Status word A (buffer, tone, FSK and DSP causes) |
| stat_b | output | 8 | Status word B (tone-pair and dial-pulse causes) |

## Verification
The bench toggles each single-bit cause by itself, first up and then back down. It measures the exact start cycle and length of every pulse, which separates edge detection in one direction from detection in both directions. The tone-pair code is stepped through every nonzero XOR pattern twice: once with presence held, where each step must produce a pulse, and once with presence low, where no step may produce one. This tells gated from ungated code comparison apart. Two further cases cover the remaining timing: a second event placed inside a running pulse, which shows whether the timer reloads or simply runs out, and a simultaneous change of six causes, which must merge into a single pulse.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int CODE_W = 4;

    typedef struct packed {
        logic              dial;
        logic [CODE_W-1:0] code;
        logic              valid;
        logic              dsp_err;
        logic              fsk;
        logic              tone1;
        logic              tone0;
        logic              ovr;
        logic              udf;
    } cause_t;

    localparam int FLAG_N = 8;

    function automatic logic [FLAG_N-1:0] flag_vec(input cause_t c);
        return {c.dial, c.valid, c.dsp_err, c.fsk, c.tone1, c.tone0, c.ovr, c.udf};
    endfunction

    localparam int SA_UDF  = 0;
    localparam int SA_OVR  = 1;
    localparam int SA_TON0 = 3;
    localparam int SA_TON1 = 4;
    localparam int SA_FSK  = 6;
    localparam int SA_DSP  = 7;
    localparam int SB_VLD  = 4;
    localparam int SB_DIAL = 6;

endpackage

// File: rtl/irq_cause_capture.sv
module irq_cause_capture
    import irq_agg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t raw,
    output cause_t cur,
    output cause_t prev
);

    typedef struct packed {
        cause_t cur;
        cause_t prev;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cur  = raw;
            st_d.prev = raw;
        end else begin
            st_d.cur  = raw;
            st_d.prev = st_q.cur;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cur  = st_q.cur;
    assign prev = st_q.prev;

endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect
    import irq_agg_pkg::*;
(
    input  cause_t cur,
    input  cause_t prev,
    output logic   event_any
);

    logic [FLAG_N-1:0] cur_f, prev_f, flip;
    logic              code_step;

    assign cur_f  = flag_vec(cur);
    assign prev_f = flag_vec(prev);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        assign flip[i] = cur_f[i] ^ prev_f[i];
    end

    always_comb begin
        code_step = 1'b0;
        if (cur.valid && prev.valid && (cur.code != prev.code)) begin
            code_step = 1'b1;
        end
        event_any = (|flip) | code_step;
    end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int PULSE_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic irq_n
);

    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.cnt = '0;
        end else if (trigger) begin
            st_d.cnt = LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign irq_n = (st_q.cnt == '0);

endmodule

// File: rtl/irq_status_pack.sv
module irq_status_pack
    import irq_agg_pkg::*;
(
    input  cause_t     cur,
    output logic [7:0] stat_a,
    output logic [7:0] stat_b
);

    always_comb begin
        stat_a          = '0;
        stat_a[SA_UDF]  = cur.udf;
        stat_a[SA_OVR]  = cur.ovr;
        stat_a[SA_TON0] = cur.tone0;
        stat_a[SA_TON1] = cur.tone1;
        stat_a[SA_FSK]  = cur.fsk;
        stat_a[SA_DSP]  = cur.dsp_err;

        stat_b               = '0;
        stat_b[CODE_W-1:0]   = cur.code;
        stat_b[SB_VLD]       = cur.valid;
        stat_b[SB_DIAL]      = cur.dial;
    end

endmodule

// File: rtl/irq_change_agg.sv
module irq_change_agg
    import irq_agg_pkg::*;
#(
    parameter int PULSE_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_underflow,
    input  logic       tx_overrun,
    input  logic       tone0_det,
    input  logic       tone1_det,
    input  logic       fsk_req,
    input  logic       dsp_err,
    input  logic       dtmf_valid,
    input  logic [3:0] dtmf_code,
    input  logic       dial_pulse,
    output logic       irq_n,
    output logic [7:0] stat_a,
    output logic [7:0] stat_b
);

    cause_t raw, cur, prev;
    logic   evt;

    always_comb begin
        raw         = '0;
        raw.udf     = rx_underflow;
        raw.ovr     = tx_overrun;
        raw.tone0   = tone0_det;
        raw.tone1   = tone1_det;
        raw.fsk     = fsk_req;
        raw.dsp_err = dsp_err;
        raw.valid   = dtmf_valid;
        raw.code    = dtmf_code;
        raw.dial    = dial_pulse;
    end

    irq_cause_capture u_cap (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .cur  (cur),
        .prev (prev)
    );

    irq_change_detect u_det (
        .cur      (cur),
        .prev     (prev),
        .event_any(evt)
    );

    irq_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trigger(evt),
        .irq_n  (irq_n)
    );

    irq_status_pack u_stat (
        .cur   (cur),
        .stat_a(stat_a),
        .stat_b(stat_b)
    );

endmodule

// File: rtl/irq_change_agg_chk.sv
module irq_change_agg_chk #(
    parameter int PULSE_CYCLES = 4096
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_underflow,
    input logic       dial_pulse,
    input logic       irq_n,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9
    stat_a_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (stat_a[0] == $past(rx_underflow)));

    // R10
    stat_b_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (stat_b[6] == $past(dial_pulse)));

    // R2 R3
    a_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && stat_a != $past(stat_a)) |=> !irq_n);

    // R5
    code_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && stat_b[4] && $past(stat_b[4]) && stat_b[3:0] != $past(stat_b[3:0])) |=> !irq_n);

    // R1
    quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && irq_n && stat_a == $past(stat_a) && stat_b[7:4] == $past(stat_b[7:4])
         && !(stat_b[4] && stat_b[3:0] != $past(stat_b[3:0]))) |=> irq_n);

endmodule

bind irq_change_agg irq_change_agg_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_underflow(rx_underflow),
    .dial_pulse  (dial_pulse),
    .irq_n       (irq_n),
    .stat_a      (stat_a),
    .stat_b      (stat_b)
);

// File: tb/irq_change_agg_tb_top.sv
module irq_change_agg_tb_top;

    localparam int P = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] iv = '0;
    logic        irq_n;
    logic [7:0]  stat_a, stat_b;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_change_agg #(.PULSE_CYCLES(P)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_underflow(iv[0]),
        .tx_overrun  (iv[1]),
        .tone0_det   (iv[2]),
        .tone1_det   (iv[3]),
        .fsk_req     (iv[4]),
        .dsp_err     (iv[5]),
        .dtmf_valid  (iv[6]),
        .dial_pulse  (iv[7]),
        .dtmf_code   (iv[11:8]),
        .irq_n       (irq_n),
        .stat_a      (stat_a),
        .stat_b      (stat_b)
    );

    function automatic logic [7:0] exp_a(logic [11:0] v);
        return {v[5], v[4], 1'b0, v[3], v[2], 1'b0, v[1], v[0]};
    endfunction

    function automatic logic [7:0] exp_b(logic [11:0] v);
        return {1'b0, v[7], 1'b0, v[6], v[11:8]};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_stat(string req);
        chk(stat_a == exp_a(iv), req, "stat_a", int'(stat_a), int'(exp_a(iv)));
        chk(stat_b == exp_b(iv), req, "stat_b", int'(stat_b), int'(exp_b(iv)));
    endtask

    // called right after inputs change at a negedge
    task automatic observe(string req, bit exp_pulse, bit first_level);
        int lows;
        @(negedge clk);
        check_stat(req);
        chk(irq_n == first_level, req, "irq_n one edge after change", int'(irq_n), int'(first_level));
        lows = 0;
        for (int k = 0; k < P + 4; k++) begin
            @(negedge clk);
            if (!irq_n) lows++;
            else break;
        end
        chk(lows == (exp_pulse ? P : 0), req, "pulse length", lows, exp_pulse ? P : 0);
        if (!exp_pulse) begin
            for (int k = 0; k < 2; k++) @(negedge clk);
            chk(irq_n == 1'b1, req, "irq_n stays high", int'(irq_n), 1);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        string rq;
        // R1: reset with active causes present
        iv = 12'h3A5;
        repeat (4) @(negedge clk);
        chk(irq_n == 1'b1, "R1", "irq_n in reset", int'(irq_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check_stat("R9");
        check_stat("R10");
        for (int k = 0; k < P + 3; k++) begin
            @(negedge clk);
            chk(irq_n == 1'b1, "R1", "irq_n after reset", int'(irq_n), 1);
        end

        // R2 R3 R4 R6 R7: each flag up then down (order depends on start value)
        for (int b = 0; b < 8; b++) begin
            for (int dir = 0; dir < 2; dir++) begin
                iv[b] = ~iv[b];
                if (b == 6)      rq = "R4";
                else if (b == 7) rq = "R6";
                else             rq = iv[b] ? "R2" : "R3";
                observe(rq, 1'b1, 1'b1);
            end
        end

        // R5: code steps while presence held
        iv[6] = 1'b1;
        observe("R4", 1'b1, 1'b1);
        for (int c = 1; c < 16; c++) begin
            iv[11:8] = iv[11:8] ^ 4'(c);
            observe("R5", 1'b1, 1'b1);
        end
        // R5 R10: code steps while presence low
        iv[6] = 1'b0;
        observe("R4", 1'b1, 1'b1);
        for (int c = 1; c < 16; c++) begin
            iv[11:8] = iv[11:8] ^ 4'(c);
            observe("R10", 1'b0, 1'b1);
        end

        // R8: restart inside pulse
        iv[0] = ~iv[0];
        repeat (3) @(negedge clk);
        chk(irq_n == 1'b0, "R8", "first pulse running", int'(irq_n), 0);
        iv[1] = ~iv[1];
        observe("R8", 1'b1, 1'b0);

        // R11: simultaneous changes
        iv[5:0] = ~iv[5:0];
        observe("R11", 1'b1, 1'b1);

        summary();
        $finish;
    end

endmodule